// File: doc/BRIEF.md
# USB Dual-Role Port Role Selector

This block decides whether a dual-role USB port currently acts as a host, as a peripheral, or as neither. It watches an identification pin and a B-session-valid pin. It also watches two flags that report whether the host stack and the peripheral stack are loaded, and a static capability setting. From these it drives the host enable, the VBUS supply enable, the peripheral connect and a mask for the session-valid interrupt. A four-state machine holds the current role. Each time the port drops out of a role, the machine fires a one-cycle link/PHY reset request. It then stays idle until the reset-done input returns, and only after that does it evaluate the inputs again.

There are four capability settings: dual-role driven by the pins, host-only, peripheral-only, and dual-role under manual control. In manual control the pins are ignored. A default role loads the decision inputs at start-up, and later role requests change them, but each request kind is honoured only from certain states. The pins pass through a synchroniser before they are used. `cap_mode_i` and `dflt_role_i` are expected to be static while reset is released.

Top module: `otg_role_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0 (undefined), and host_en_o, vbus_en_o, periph_conn_o, bsv_irq_mask_o and link_rst_o are all 0. State codes are 0 undefined, 1 idle, 2 peripheral, 3 host.
- R2: From the undefined state, the block moves to idle on the next clock. In that same step it loads its decision inputs, and link_rst_o is high for exactly one cycle.
- R3: After any link_rst_o pulse, the idle state makes no role decision until rst_done_i has been seen high for a cycle.
- R4: In idle, ID low with host_fn_i high enters the host state (3). This check has priority over the peripheral check. In the host state host_en_o, vbus_en_o and bsv_irq_mask_o are 1.
- R5: Otherwise in idle, ID high with session valid high and periph_fn_i high enters the peripheral state (2), where periph_conn_o is 1.
- R6: In the peripheral state, session valid low or ID low returns the block to idle, pulses link_rst_o, and re-evaluates after rst_done_i.
- R7: In the host state, ID high returns the block to idle with vbus_en_o off, pulses link_rst_o, and re-evaluates after rst_done_i.
- R8: Dropping the active role's function flag (host_fn_i in host, periph_fn_i in peripheral) sends the block back to the undefined state. The undefined state then reloads the inputs as in R2.
- R9: With cap_mode_i = 1 (host-only), ID is taken as low and session valid as low whatever the pins show.
- R10: With cap_mode_i = 2 (peripheral-only), ID is taken as high and session valid follows its pin. cap_mode_i = 0 makes both follow their pins.
- R11: With cap_mode_i = 3 (manual), the pins are ignored. The undefined state loads ID/session valid from dflt_role_i: 2 host gives ID low and session low; 1 peripheral gives both high; 0 none (or 3) gives ID high and session low.
- R12: A request (req_vld_i high for one cycle, code on req_role_i) acts only in manual mode. Code 0 (none) is honoured in host or peripheral and sets ID high with session low. Code 1 (peripheral) is honoured in idle or host and sets both high. Code 2 (host) is honoured in idle or peripheral and sets ID low. Any other request is ignored.
- R13: A pin change reaches the role outputs no sooner than four clock edges after it is applied (two synchroniser flops, the input latch, the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_mode_i | input | 2 | Capability: 0 pin dual-role, 1 host-only, 2 peripheral-only, 3 manual |
| dflt_role_i | input | 2 | Default role for manual mode: 0 none, 1 peripheral, 2 host |
| id_pin_i | input | 1 | Identification pin, asynchronous |
| bsv_pin_i | input | 1 | B-session-valid pin, asynchronous |
| host_fn_i | input | 1 | Host stack present |
| periph_fn_i | input | 1 | Peripheral stack present |
| req_vld_i | input | 1 | Manual role request strobe |
| req_role_i | input | 2 | Requested role code |
| rst_done_i | input | 1 | Link/PHY reset finished |
| host_en_o | output | 1 | Host operation enable |
| vbus_en_o | output | 1 | VBUS supply enable |
| periph_conn_o | output | 1 | Peripheral connect |
| bsv_irq_mask_o | output | 1 | Session-valid interrupt masked |
| link_rst_o | output | 1 | One-cycle link/PHY reset request |
| state_o | output | 2 | Current state code |

## Verification
The bench aims at the points where role priority and re-evaluation can go wrong. One is ID low together with a valid session: a design that tested the peripheral first would connect the peripheral instead of driving VBUS. Another is a host-to-peripheral hand-over, where a block that skipped re-evaluation after reset would park in idle. A third is rst_done_i held off, where a design that ignores it would enter a role too early. Function removal under manual control is checked by watching the default role come back, which a design that returned to idle instead of the undefined state would miss. Rejected manual requests are checked through a later role change that would differ had the request been taken, and pin-to-output latency is checked against the synchroniser depth.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;
  typedef enum logic [1:0] {
    ST_UNDEF    = 2'd0,
    ST_B_IDLE   = 2'd1,
    ST_B_PERIPH = 2'd2,
    ST_A_HOST   = 2'd3
  } otg_state_e;

  typedef enum logic [1:0] {
    CAP_DUAL_PIN    = 2'd0,
    CAP_HOST_ONLY   = 2'd1,
    CAP_PERIPH_ONLY = 2'd2,
    CAP_DUAL_MANUAL = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    ROLE_NONE   = 2'd0,
    ROLE_PERIPH = 2'd1,
    ROLE_HOST   = 2'd2,
    ROLE_RSVD   = 2'd3
  } role_e;
endpackage

// File: rtl/otg_pin_sync.sv
module otg_pin_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/otg_role_inputs.sv
module otg_role_inputs
  import otg_role_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cap_mode_e  cap_mode_i,
  input  logic       id_pin_i,
  input  logic       bsv_pin_i,
  input  logic       load_init_i,
  input  otg_state_e state_i,
  input  logic       req_vld_i,
  input  role_e      req_role_i,
  input  role_e      dflt_role_i,
  output logic       id_o,
  output logic       bsv_o
);
  logic id_q, bsv_q, id_d, bsv_d;

  always_comb begin
    id_d  = id_q;
    bsv_d = bsv_q;
    case (cap_mode_i)
      CAP_HOST_ONLY: begin
        id_d  = 1'b0;
        bsv_d = 1'b0;
      end
      CAP_PERIPH_ONLY: begin
        id_d  = 1'b1;
        bsv_d = bsv_pin_i;
      end
      CAP_DUAL_PIN: begin
        id_d  = id_pin_i;
        bsv_d = bsv_pin_i;
      end
      default: begin
        if (load_init_i) begin
          case (dflt_role_i)
            ROLE_HOST:   begin id_d = 1'b0; bsv_d = 1'b0; end
            ROLE_PERIPH: begin id_d = 1'b1; bsv_d = 1'b1; end
            default:     begin id_d = 1'b1; bsv_d = 1'b0; end
          endcase
        end else if (req_vld_i) begin
          case (req_role_i)
            ROLE_NONE:
              if (state_i == ST_A_HOST || state_i == ST_B_PERIPH) begin
                id_d  = 1'b1;
                bsv_d = 1'b0;
              end
            ROLE_PERIPH:
              if (state_i == ST_B_IDLE || state_i == ST_A_HOST) begin
                id_d  = 1'b1;
                bsv_d = 1'b1;
              end
            ROLE_HOST:
              if (state_i == ST_B_IDLE || state_i == ST_B_PERIPH) id_d = 1'b0;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= 1'b1;
      bsv_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      bsv_q <= bsv_d;
    end
  end

  assign id_o  = id_q;
  assign bsv_o = bsv_q;
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
  import otg_role_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       id_i,
  input  logic       bsv_i,
  input  logic       host_fn_i,
  input  logic       periph_fn_i,
  input  logic       rst_done_i,
  output otg_state_e state_o,
  output logic       load_init_o,
  output logic       link_rst_o
);
  otg_state_e state_q, state_d;
  logic       wait_q, wait_d;
  logic       pulse_q, fire;

  always_comb begin
    state_d     = state_q;
    fire        = 1'b0;
    load_init_o = 1'b0;
    case (state_q)
      ST_UNDEF: begin
        load_init_o = 1'b1;
        fire        = 1'b1;
        state_d     = ST_B_IDLE;
      end
      ST_B_IDLE: begin
        // decide only once the last link reset has completed
        if (!wait_q) begin
          if (!id_i && host_fn_i)                 state_d = ST_A_HOST;
          else if (id_i && bsv_i && periph_fn_i)  state_d = ST_B_PERIPH;
        end
      end
      ST_B_PERIPH: begin
        if (!periph_fn_i) begin
          state_d = ST_UNDEF;
        end else if (!bsv_i || !id_i) begin
          state_d = ST_B_IDLE;
          fire    = 1'b1;
        end
      end
      ST_A_HOST: begin
        if (!host_fn_i) begin
          state_d = ST_UNDEF;
        end else if (id_i) begin
          state_d = ST_B_IDLE;
          fire    = 1'b1;
        end
      end
      default: state_d = ST_UNDEF;
    endcase
    wait_d = fire ? 1'b1 : (rst_done_i ? 1'b0 : wait_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNDEF;
      wait_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      pulse_q <= fire;
    end
  end

  assign state_o    = state_q;
  assign link_rst_o = pulse_q;
endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
  import otg_role_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cap_mode_i,
  input  logic [1:0] dflt_role_i,
  input  logic       id_pin_i,
  input  logic       bsv_pin_i,
  input  logic       host_fn_i,
  input  logic       periph_fn_i,
  input  logic       req_vld_i,
  input  logic [1:0] req_role_i,
  input  logic       rst_done_i,
  output logic       host_en_o,
  output logic       vbus_en_o,
  output logic       periph_conn_o,
  output logic       bsv_irq_mask_o,
  output logic       link_rst_o,
  output logic [1:0] state_o
);
  localparam int              NUM_PINS = 2;
  localparam int              PIN_ID   = 0;
  localparam int              PIN_BSV  = 1;
  localparam logic [NUM_PINS-1:0] PIN_RST = NUM_PINS'(1 << PIN_ID);

  logic [NUM_PINS-1:0] pin_raw, pin_sync;
  logic                id_eff, bsv_eff, load_init;
  otg_state_e          state;

  assign pin_raw[PIN_ID]  = id_pin_i;
  assign pin_raw[PIN_BSV] = bsv_pin_i;

  otg_pin_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_sync)
  );

  otg_role_inputs u_inputs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_mode_i (cap_mode_e'(cap_mode_i)),
    .id_pin_i   (pin_sync[PIN_ID]),
    .bsv_pin_i  (pin_sync[PIN_BSV]),
    .load_init_i(load_init),
    .state_i    (state),
    .req_vld_i  (req_vld_i),
    .req_role_i (role_e'(req_role_i)),
    .dflt_role_i(role_e'(dflt_role_i)),
    .id_o       (id_eff),
    .bsv_o      (bsv_eff)
  );

  otg_role_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_i       (id_eff),
    .bsv_i      (bsv_eff),
    .host_fn_i  (host_fn_i),
    .periph_fn_i(periph_fn_i),
    .rst_done_i (rst_done_i),
    .state_o    (state),
    .load_init_o(load_init),
    .link_rst_o (link_rst_o)
  );

  assign host_en_o      = (state == ST_A_HOST);
  assign vbus_en_o      = (state == ST_A_HOST);
  assign bsv_irq_mask_o = (state == ST_A_HOST);
  assign periph_conn_o  = (state == ST_B_PERIPH);
  assign state_o        = state;
endmodule

// File: rtl/otg_role_ctrl_chk.sv
module otg_role_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cap_mode_i,
  input logic       host_en_o,
  input logic       vbus_en_o,
  input logic       periph_conn_o,
  input logic       link_rst_o,
  input logic [1:0] state_o
);
  // R2
  undef_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |=> state_o == 2'd1 && link_rst_o);

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_o |=> !link_rst_o);

  // R4
  host_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_en_o) |-> $past(state_o) == 2'd1 && !$past(link_rst_o));

  // R5
  periph_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(periph_conn_o) |-> $past(state_o) == 2'd1 && !$past(link_rst_o));

  // R7
  vbus_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vbus_en_o) |-> link_rst_o || state_o == 2'd0);

  // R9
  host_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mode_i == 2'd1 |-> !periph_conn_o);

  // R10
  periph_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mode_i == 2'd2 |-> !host_en_o);
endmodule

bind otg_role_ctrl otg_role_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cap_mode_i   (cap_mode_i),
  .host_en_o    (host_en_o),
  .vbus_en_o    (vbus_en_o),
  .periph_conn_o(periph_conn_o),
  .link_rst_o   (link_rst_o),
  .state_o      (state_o)
);

// File: tb/otg_role_ctrl_bench.sv
`timescale 1ns/1ps
module otg_role_ctrl_bench;
  localparam logic [1:0] S_UNDEF = 2'd0, S_IDLE = 2'd1, S_PER = 2'd2, S_HOST = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cap_mode = 2'd0, dflt_role = 2'd0, req_role = 2'd0;
  logic       id_pin = 1'b1, bsv_pin = 1'b0, host_fn = 1'b0, periph_fn = 1'b0;
  logic       req_vld = 1'b0, rst_done = 1'b0;
  logic       host_en, vbus_en, periph_conn, bsv_mask, link_rst;
  logic [1:0] state;

  int  total = 0, bad = 0, pulse_cnt = 0, snap = 0;
  bit  auto_done = 1'b1;
  bit  m_id, m_bsv;

  always #2.5 clk = ~clk;

  otg_role_ctrl u_otg_role_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cap_mode_i(cap_mode), .dflt_role_i(dflt_role),
    .id_pin_i(id_pin), .bsv_pin_i(bsv_pin), .host_fn_i(host_fn), .periph_fn_i(periph_fn),
    .req_vld_i(req_vld), .req_role_i(req_role), .rst_done_i(rst_done),
    .host_en_o(host_en), .vbus_en_o(vbus_en), .periph_conn_o(periph_conn),
    .bsv_irq_mask_o(bsv_mask), .link_rst_o(link_rst), .state_o(state)
  );

  function automatic logic [1:0] settle(bit id, bit bsv, bit hf, bit pf);
    if (!id && hf) return S_HOST;
    if (id && bsv && pf) return S_PER;
    return S_IDLE;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic check_role(string req, logic [1:0] exp);
    chk(req, "state", 32'(state), 32'(exp));
    chk(req, "host_en", 32'(host_en), 32'(exp == S_HOST));
    chk(req, "vbus_en", 32'(vbus_en), 32'(exp == S_HOST));
    chk(req, "bsv_mask", 32'(bsv_mask), 32'(exp == S_HOST));
    chk(req, "periph_conn", 32'(periph_conn), 32'(exp == S_PER));
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(logic [1:0] mode, logic [1:0] dflt);
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(2);
    cap_mode  = mode;
    dflt_role = dflt;
    wait_n(2);
    rst_n = 1'b1;
  endtask

  task automatic request(logic [1:0] code);
    @(negedge clk);
    req_role = code;
    req_vld  = 1'b1;
    @(negedge clk);
    req_vld  = 1'b0;
  endtask

  // manual-mode reference for R12
  task automatic model_req(logic [1:0] code, logic [1:0] st);
    case (code)
      2'd0: if (st == S_HOST || st == S_PER) begin m_id = 1'b1; m_bsv = 1'b0; end
      2'd1: if (st == S_IDLE || st == S_HOST) begin m_id = 1'b1; m_bsv = 1'b1; end
      2'd2: if (st == S_IDLE || st == S_PER) m_id = 1'b0;
      default: ;
    endcase
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial forever begin
    @(posedge clk);
    if (link_rst) pulse_cnt++;
  end

  initial forever begin
    @(posedge clk);
    if (link_rst && auto_done) begin
      repeat (3) @(negedge clk);
      rst_done = 1'b1;
      @(negedge clk);
      rst_done = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-reqs: got hang exp completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));

    // R1 reset state
    wait_n(3);
    check_role("R1", S_UNDEF);
    chk("R1", "link_rst", 32'(link_rst), 32'd0);

    // R2 undefined -> idle with a single pulse
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "state", 32'(state), 32'(S_IDLE));
    chk("R2", "link_rst", 32'(link_rst), 32'd1);
    @(negedge clk);
    chk("R2", "link_rst after", 32'(link_rst), 32'd0);
    wait_n(20);

    // R13 synchroniser latency
    id_pin = 1'b1; bsv_pin = 1'b1; periph_fn = 1'b1;
    wait_n(3);
    chk("R13", "periph_conn early", 32'(periph_conn), 32'd0);
    wait_n(1);
    chk("R13", "periph_conn on time", 32'(periph_conn), 32'd1);

    // R3 no decision before reset done
    auto_done = 1'b0;
    id_pin = 1'b0; bsv_pin = 1'b0; host_fn = 1'b1; periph_fn = 1'b0;
    restart(2'd0, 2'd0);
    wait_n(20);
    check_role("R3", S_IDLE);
    rst_done = 1'b1;
    @(negedge clk);
    rst_done = 1'b0;
    wait_n(2);
    check_role("R3", S_HOST);
    auto_done = 1'b1;

    // R4 host wins over valid session
    bsv_pin = 1'b1; periph_fn = 1'b1;
    wait_n(20);
    check_role("R4", S_HOST);

    // R7 id high leaves host, re-evaluates into peripheral
    snap = pulse_cnt;
    id_pin = 1'b1;
    wait_n(30);
    check_role("R7", S_PER);
    chk("R7", "pulses", 32'(pulse_cnt - snap), 32'd1);

    // R6 session loss leaves peripheral
    snap = pulse_cnt;
    bsv_pin = 1'b0;
    wait_n(30);
    check_role("R6", S_IDLE);
    chk("R6", "pulses", 32'(pulse_cnt - snap), 32'd1);
    bsv_pin = 1'b1;
    wait_n(30);
    check_role("R5", S_PER);
    snap = pulse_cnt;
    host_fn = 1'b0; id_pin = 1'b0;
    wait_n(30);
    check_role("R6", S_IDLE);
    chk("R6", "pulses id low", 32'(pulse_cnt - snap), 32'd1);

    // R8 host function removal in pin mode
    host_fn = 1'b1;
    wait_n(30);
    check_role("R4", S_HOST);
    snap = pulse_cnt;
    host_fn = 1'b0;
    wait_n(30);
    check_role("R8", S_IDLE);
    chk("R8", "pulses", 32'(pulse_cnt - snap), 32'd1);

    // R4 R5 R6 R7 R8 random pin-driven patterns
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      id_pin    = 1'($urandom);
      bsv_pin   = 1'($urandom);
      host_fn   = 1'($urandom);
      periph_fn = 1'($urandom);
      wait_n(30);
      check_role("R5", settle(id_pin, bsv_pin, host_fn, periph_fn));
    end

    // R12 requests ignored outside manual mode
    id_pin = 1'b1; bsv_pin = 1'b0; host_fn = 1'b1; periph_fn = 1'b1;
    restart(2'd0, 2'd0);
    wait_n(30);
    request(2'd1);
    wait_n(30);
    check_role("R12", S_IDLE);

    // R9 host-only
    id_pin = 1'b1; bsv_pin = 1'b1; host_fn = 1'b1; periph_fn = 1'b1;
    restart(2'd1, 2'd0);
    wait_n(30);
    check_role("R9", S_HOST);
    host_fn = 1'b0;
    wait_n(30);
    check_role("R9", S_IDLE);

    // R10 peripheral-only
    id_pin = 1'b0; bsv_pin = 1'b1; host_fn = 1'b1; periph_fn = 1'b1;
    restart(2'd2, 2'd0);
    wait_n(30);
    check_role("R10", S_PER);
    bsv_pin = 1'b0;
    wait_n(30);
    check_role("R10", S_IDLE);
    bsv_pin = 1'b1;
    wait_n(30);
    check_role("R10", S_PER);

    // R11 manual defaults, pins ignored
    id_pin = 1'b0; bsv_pin = 1'b0; host_fn = 1'b1; periph_fn = 1'b1;
    restart(2'd3, 2'd1);
    wait_n(30);
    check_role("R11", S_PER);
    id_pin = 1'b1; bsv_pin = 1'b0;
    wait_n(30);
    check_role("R11", S_PER);
    restart(2'd3, 2'd0);
    wait_n(30);
    check_role("R11", S_IDLE);
    restart(2'd3, 2'd2);
    wait_n(30);
    check_role("R11", S_HOST);

    // R12 'none' rejected in idle
    host_fn = 1'b0;
    restart(2'd3, 2'd2);
    wait_n(30);
    check_role("R12", S_IDLE);
    request(2'd0);
    wait_n(5);
    host_fn = 1'b1;
    wait_n(30);
    check_role("R12", S_HOST);

    // R8 manual: removal reloads default
    request(2'd1);
    wait_n(30);
    check_role("R12", S_PER);
    periph_fn = 1'b0;
    wait_n(30);
    check_role("R8", S_HOST);
    periph_fn = 1'b1;

    // R12 random manual requests
    restart(2'd3, 2'd0);
    m_id = 1'b1; m_bsv = 1'b0;
    wait_n(30);
    for (int i = 0; i < 40; i++) begin
      logic [1:0] code;
      code = 2'($urandom);
      model_req(code, state);
      request(code);
      bsv_pin = 1'($urandom);
      id_pin  = 1'($urandom);
      wait_n(30);
      check_role("R12", settle(m_id, m_bsv, 1'b1, 1'b1));
    end

    summary();
    $finish;
  end
endmodule